// File: doc/BRIEF.md
# Output Driver Mismatch Checker

This block guards a bank of output pins against driver faults. Each cycle it takes the value the core wants on each pin, the per-pin drive enable, and the level read back from each pad. Every pin has its own comparator. The comparator flags a pin only when the core wants that pin driven and the pad level differs from the intended value. Hits are gathered into a sticky per-pin error vector and a single summary flag. Both stay set until the clear input is raised.

The pad levels are registered together with the intended values and enables before they are compared. Driver delay within a cycle therefore cannot raise a false error.

There are two operating modes.
- **Drive mode:** the block passes the core's enables to the pad drivers. Used this way it catches pins that are shorted to another level. A pin that is open can still read back the correct value, so an open pin is not guaranteed to be caught.
- **Shadow mode:** the block is placed beside a master twin that runs the same program. All of its own drivers are switched off. It compares its internally computed values against the pads the master drives, wherever its own enable pattern says the master should be driving. This catches open pins and wrong master outputs.

The sample taken in the first cycle after a mode change is ignored, because the pads are still settling.

The pin data is a level on every cycle, not a stream, so there is no valid/ready pair and no back-pressure. All ports are plain control or status pins.

Top module: `pad_mismatch_checker`

## Requirements
- R1: In drive mode (`checker_mode` = 0), `pad_oe` equals `core_oe` in the same cycle.
- R2: In shadow mode (`checker_mode` = 1), every bit of `pad_oe` is 0.
- R3: `core_val`, `core_oe` and `pad_in` are captured at the same clock edge. After that edge, `mism_vec[i]` is 1 exactly when the captured enable bit i is 1 and the captured value bit i differs from the captured pad bit i.
- R4: A pin whose captured enable is 0 never sets its `mism_vec` or `err_vec` bit, whatever its pad level is.
- R5: In shadow mode the comparison uses the internally computed `core_oe` as the expected drive pattern. A pad that stays at the wrong level (for example an open pin, or a master fault) is flagged.
- R6: If the mode captured at an edge differs from the mode captured at the previous edge, then every bit of `mism_vec` is 0 for the sample taken at that edge.
- R7: At each clock edge, `err_vec` takes the OR of its old value and `mism_vec`. Bits never fall except through `clr`.
- R8: When `clr` is 1 at an edge, `err_vec` becomes all zero after that edge. This holds even if `mism_vec` is non-zero in the same cycle.
- R9: `err_any` is 1 exactly when at least one bit of `err_vec` is 1.
- R10: While `rst_n` is 0, `err_vec`, `err_any` and `mism_vec` are all 0, and so are the capture registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| checker_mode | input | 1 | 0 = drive mode, 1 = shadow mode (own drivers off) |
| clr | input | 1 | Synchronous clear of the sticky errors |
| core_val | input | W | Value the core intends for each pin |
| core_oe | input | W | Per-pin drive enable computed by the core |
| pad_in | input | W | Level observed on each pad |
| pad_oe | output | W | Enables sent to the pad drivers |
| mism_vec | output | W | Per-pin mismatch for the sample captured at the last edge |
| err_vec | output | W | Sticky per-pin error vector |
| err_any | output | 1 | OR of `err_vec` |

## Verification
The assertions assume three things about the inputs:
- `clr`, `checker_mode` and the core signals are synchronous to `clk`.
- The pad levels have settled before the edge that samples them.
- The enable pattern seen in one cycle is the pattern that governs the pad sample taken at the next edge.

The bench keeps within these rules. It changes every input only at the falling edge. It builds each pad value from the intended value and a fault mask, so a mismatch exists only where the bench injects one. Mode changes and clears come at random but rarely, with directed cases placed on the mode-change and clear-with-hit edges.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic {
    MODE_DRIVE  = 1'b0,
    MODE_SHADOW = 1'b1
  } pmc_mode_e;

  localparam int unsigned PMC_DEFAULT_W = 16;
endpackage

// File: rtl/pmc_capture.sv
module pmc_capture #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] oe_i,
  input  logic [W-1:0] pad_i,
  input  logic         mode_i,
  output logic [W-1:0] val_q,
  output logic [W-1:0] oe_q,
  output logic [W-1:0] pad_q,
  output logic         blank_q
);
  logic mode_q;

  // All three vectors are captured at the same edge so that they stay aligned.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q   <= '0;
      oe_q    <= '0;
      pad_q   <= '0;
      mode_q  <= 1'b0;
      blank_q <= 1'b0;
    end else begin
      val_q   <= val_i;
      oe_q    <= oe_i;
      pad_q   <= pad_i;
      blank_q <= (mode_i != mode_q);
      mode_q  <= mode_i;
    end
  end
endmodule

// File: rtl/pmc_bit_cmp.sv
module pmc_bit_cmp (
  input  logic want,
  input  logic en,
  input  logic seen,
  input  logic blank,
  output logic hit
);
  always_comb begin
    hit = 1'b0;
    if (en && !blank) hit = (want != seen);
  end
endmodule

// File: rtl/pmc_err_hold.sv
module pmc_err_hold #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] hit_i,
  output logic [W-1:0] err_q,
  output logic         any_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   err_q <= '0;
    else if (clr) err_q <= '0;
    else          err_q <= err_q | hit_i;
  end

  assign any_o = |err_q;
endmodule

// File: rtl/pad_mismatch_checker.sv
module pad_mismatch_checker
  import pmc_pkg::*;
#(
  parameter int unsigned W = PMC_DEFAULT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         checker_mode,
  input  logic         clr,
  input  logic [W-1:0] core_val,
  input  logic [W-1:0] core_oe,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] mism_vec,
  output logic [W-1:0] err_vec,
  output logic         err_any
);
  pmc_mode_e    mode_e;
  logic [W-1:0] val_q, oe_q, pad_q;
  logic         blank_q;

  assign mode_e = pmc_mode_e'(checker_mode);
  assign pad_oe = (mode_e == MODE_SHADOW) ? '0 : core_oe;

  pmc_capture #(.W(W)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .val_i(core_val), .oe_i(core_oe), .pad_i(pad_in), .mode_i(checker_mode),
    .val_q(val_q), .oe_q(oe_q), .pad_q(pad_q), .blank_q(blank_q)
  );

  for (genvar i = 0; i < W; i++) begin : g_bit
    pmc_bit_cmp u_cmp (
      .want(val_q[i]), .en(oe_q[i]), .seen(pad_q[i]),
      .blank(blank_q), .hit(mism_vec[i])
    );
  end

  pmc_err_hold #(.W(W)) u_hold (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .hit_i(mism_vec), .err_q(err_vec), .any_o(err_any)
  );
endmodule

// File: rtl/pad_mismatch_checker_sva.sv
module pad_mismatch_checker_sva #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         checker_mode,
  input logic         clr,
  input logic [W-1:0] core_oe,
  input logic [W-1:0] pad_oe,
  input logic [W-1:0] mism_vec,
  input logic [W-1:0] err_vec,
  input logic         err_any
);
  // R2
  shadow_drivers_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    checker_mode |-> (pad_oe == '0));

  // R1
  drive_oe_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !checker_mode |-> (pad_oe == core_oe));

  // R4
  masked_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((mism_vec & ~$past(core_oe)) == '0));

  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((err_vec & $past(err_vec | mism_vec)) == $past(err_vec | mism_vec)));

  // R8
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (err_vec == '0));

  // R9
  any_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_any == (err_vec != '0));

  // R6
  mode_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (checker_mode != $past(checker_mode)) |=> (mism_vec == '0));
endmodule

bind pad_mismatch_checker pad_mismatch_checker_sva #(.W(W)) u_sva (
  .clk(clk), .rst_n(rst_n), .checker_mode(checker_mode), .clr(clr),
  .core_oe(core_oe), .pad_oe(pad_oe), .mism_vec(mism_vec),
  .err_vec(err_vec), .err_any(err_any)
);

// File: tb/pad_mismatch_checker_tb.sv
module pad_mismatch_checker_tb;
  localparam int W = 16;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         checker_mode = 1'b0;
  logic         clr = 1'b0;
  logic [W-1:0] core_val = '0, core_oe = '0, pad_in = '0;
  logic [W-1:0] pad_oe, mism_vec, err_vec;
  logic         err_any;

  int checks = 0;
  int fails  = 0;

  // bench model state
  logic [W-1:0] m_val = '0, m_oe = '0, m_pad = '0, m_err = '0;
  logic         m_mode = 1'b0, m_blank = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pad_mismatch_checker #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .checker_mode(checker_mode), .clr(clr),
    .core_val(core_val), .core_oe(core_oe), .pad_in(pad_in),
    .pad_oe(pad_oe), .mism_vec(mism_vec), .err_vec(err_vec), .err_any(err_any)
  );

  function automatic logic [W-1:0] exp_hits();
    if (m_blank) return '0;
    return m_oe & (m_val ^ m_pad);
  endfunction

  function automatic logic [W-1:0] exp_oe(logic mode, logic [W-1:0] oe);
    return mode ? '0 : oe;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic [W-1:0] v, logic [W-1:0] oe, logic [W-1:0] fault,
                      logic mode, logic c);
    logic [W-1:0] hits;
    @(negedge clk);
    core_val = v; core_oe = oe; pad_in = v ^ fault; checker_mode = mode; clr = c;
    #1;
    check(mode ? "R2 pad_oe" : "R1 pad_oe", pad_oe, exp_oe(mode, oe));
    @(posedge clk);
    #1;
    hits    = exp_hits();
    m_err   = c ? '0 : (m_err | hits);
    m_blank = (mode != m_mode);
    m_mode  = mode;
    m_val   = v; m_oe = oe; m_pad = v ^ fault;
    check("R3 mism_vec", mism_vec, exp_hits());
    check("R7 err_vec", err_vec, m_err);
    check("R9 err_any", {{(W-1){1'b0}}, err_any}, {{(W-1){1'b0}}, (m_err != '0)});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    check("R10 err_vec reset", err_vec, '0);
    check("R10 mism_vec reset", mism_vec, '0);
    check("R10 err_any reset", {{(W-1){1'b0}}, err_any}, '0);
    @(negedge clk);
    rst_n = 1'b1;

    // clean traffic
    step(16'hA5A5, 16'hFFFF, 16'h0000, 1'b0, 1'b0);
    step(16'h5A5A, 16'hFFFF, 16'h0000, 1'b0, 1'b0);

    // R4: faults only on disabled pins
    step(16'h1234, 16'h00FF, 16'hFF00, 1'b0, 1'b0);
    step(16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b0);
    check("R4 masked pins silent", err_vec, '0);

    // R3: short on bit 0
    step(16'h0001, 16'h0001, 16'h0001, 1'b0, 1'b0);
    step(16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b0);
    check("R3 bit0 flagged", err_vec, 16'h0001);
    step(16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b0);
    check("R7 bit0 held", err_vec, 16'h0001);

    // R8: clear in the cycle a hit is pending
    step(16'h8000, 16'h8000, 16'h8000, 1'b0, 1'b0);
    check("R8 hit pending", mism_vec, 16'h8000);
    step(16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b1);
    check("R8 clear wins", err_vec, '0);

    // R6: first shadow sample ignored
    step(16'hFFFF, 16'hFFFF, 16'h00F0, 1'b1, 1'b0);
    check("R6 blank after mode change", mism_vec, '0);
    // R5: open pins (pad stuck low) flagged in shadow mode
    step(16'hFFFF, 16'hFFFF, 16'h0F00, 1'b1, 1'b0);
    step(16'h0000, 16'h0000, 16'h0000, 1'b1, 1'b0);
    check("R5 open pins caught", err_vec, 16'h0F00);
    step(16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b1);

    // random traffic
    for (int n = 0; n < 1500; n++) begin
      logic [W-1:0] v, oe, f;
      logic md, c;
      v  = W'($urandom);
      oe = W'($urandom);
      f  = W'($urandom & $urandom & $urandom);
      if (($urandom % 4) != 0) f = '0;
      md = (($urandom % 16) == 0) ? ~checker_mode : checker_mode;
      c  = (($urandom % 20) == 0);
      step(v, oe, f, md, c);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule